// File: doc/BRIEF.md
# SIMD Immediate Expansion and Write Unit

This unit carries out the vector move-immediate operation of a SIMD datapath. One command carries an 8-bit immediate, a 4-bit mode field, an op bit, a size bit and a destination register index. The unit turns the immediate into a 64-bit pattern. The mode field picks how: a shifted word, a shifted halfword, a word shifted with a ones fill, a repeated byte, or a byte mask. The pattern is then written once or twice into a 128-bit destination register of a built-in 32-entry vector register file. A combinational read port lets the surrounding logic, or a bench, see any register.

Commands arrive on a valid/ready input. The control has two states.
- `ST_INIT` holds while synchronous reset is asserted, and `cmd_ready` is low in it. The transition `INIT_TO_ACTIVE` is taken on the first clock edge at which reset is low.
- `ST_ACTIVE` keeps `cmd_ready` high. Its only transition, `ACTIVE_TO_INIT`, is taken at a clock edge where reset is asserted.

Every accepted command is captured into one stage register. In the next cycle it appears on the write port, and the register file takes it at the end of that cycle. The latency is therefore fixed and does not depend on the data. A mode the unit does not define raises an error flag in that same cycle instead of writing.

Top module: `movi_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cmd_ready` is low after that edge. After reset, every register-file entry reads as zero.
- R2: One clock edge after reset is released, `cmd_ready` is high and stays high. A command is accepted on every edge where `cmd_valid` is high, including back-to-back cycles.
- R3: Mode `0xx0` (bit 3 and bit 0 clear) is the word form. The immediate is shifted left by 8 × mode[2:1] bits into a 32-bit word, and that word fills both halves of the 64-bit pattern.
- R4: Mode `10x0` is the halfword form. The immediate is shifted left by 8 × mode[1] bits into a 16-bit halfword, and that halfword is repeated four times in the pattern.
- R5: Mode `110x` is the ones-fill form. The immediate is shifted left by 8 bits (mode[0]=0) or 16 bits (mode[0]=1) into a 32-bit word, the vacated low bits are set to one, and the word fills both halves of the pattern.
- R6: Mode `1110` with op=0 is the byte form: the immediate is copied into all eight bytes of the pattern.
- R7: Mode `1110` with op=1 is the mask form. Pattern byte k (bits 8k+7..8k) is all ones when immediate bit k is 1 and all zeros when it is 0, so immediate bit 7 controls the top byte.
- R8: With size bit `cmd_q`=1, the 128-bit write value is the pattern repeated twice. With `cmd_q`=0, bits 63:0 hold the pattern and bits 127:64 are written as zero.
- R9: Modes `0xx1`, `10x1` and `1111` are illegal. One cycle after acceptance, `illegal` is high for one cycle and `wr_en` stays low, so the destination register keeps its previous value.
- R10: A legal command accepted at edge N drives `wr_en`, `wr_idx` and `wr_data` for exactly the cycle after N. The new value is visible on `rd_data` after edge N+1, whatever the data.
- R11: The op bit has no effect in any mode other than `1110`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit accepts a command this cycle |
| cmd_imm8 | input | 8 | Immediate byte |
| cmd_mode | input | 4 | Expansion mode field |
| cmd_op | input | 1 | Selects mask form in mode 1110 |
| cmd_q | input | 1 | 1: 128-bit write, 0: 64-bit write with upper half cleared |
| cmd_dst | input | 5 | Destination register index |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Register being written |
| wr_data | output | 128 | Value being written |
| illegal | output | 1 | Pulses for an accepted illegal mode |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 128 | Read port data (combinational) |

## Verification
The stage register and the control state are the only internal state outside the register file, and a fault in either shows up on the write port one cycle after the command. A bad stage register shows as a wrong strobe, index or value. A bad state shows as `cmd_ready` low when it should be high. A corrupted register-file entry shows only when that entry is read. For this reason every command is followed by a read-back of its destination against a shadow copy of all 32 registers. Illegal modes are aimed at registers that already hold known values, so a write that should have been suppressed shows up on the very next read.

// File: rtl/movi_pkg.sv
package movi_pkg;
    localparam int PAT_W  = 64;
    localparam int IMM_W  = 8;
    localparam int MODE_W = 4;

    typedef enum logic [2:0] {
        FORM_WORD,
        FORM_HALF,
        FORM_ONES,
        FORM_BYTE,
        FORM_MASK,
        FORM_BAD
    } form_e;

    typedef enum logic {
        ST_INIT,
        ST_ACTIVE
    } ctl_state_e;
endpackage

// File: rtl/movi_decode.sv
module movi_decode
    import movi_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              op,
    output form_e             form
);
    always_comb begin
        if (!mode[3] && !mode[0])
            form = FORM_WORD;
        else if (mode[3:2] == 2'b10 && !mode[0])
            form = FORM_HALF;
        else if (mode[3:1] == 3'b110)
            form = FORM_ONES;
        else if (mode == 4'b1110)
            form = op ? FORM_MASK : FORM_BYTE;
        else
            form = FORM_BAD;
    end
endmodule

// File: rtl/movi_expand.sv
module movi_expand
    import movi_pkg::*;
(
    input  form_e             form,
    input  logic [MODE_W-1:0] mode,
    input  logic [IMM_W-1:0]  imm,
    output logic [PAT_W-1:0]  pat
);
    localparam int NBYTES = PAT_W / 8;

    logic [31:0]      word_v;
    logic [15:0]      half_v;
    logic [31:0]      ones_v;
    logic [4:0]       ones_sh;
    logic [PAT_W-1:0] mask_v;

    for (genvar b = 0; b < NBYTES; b++) begin : g_mask
        assign mask_v[b*8 +: 8] = {8{imm[b]}};
    end

    always_comb begin
        word_v  = {24'd0, imm} << {mode[2:1], 3'b000};
        half_v  = {8'd0, imm} << {mode[1], 3'b000};
        ones_sh = mode[0] ? 5'd16 : 5'd8;
        ones_v  = ({24'd0, imm} << ones_sh) | ((32'd1 << ones_sh) - 32'd1);
    end

    always_comb begin
        unique case (form)
            FORM_WORD: pat = {word_v, word_v};
            FORM_HALF: pat = {4{half_v}};
            FORM_ONES: pat = {ones_v, ones_v};
            FORM_BYTE: pat = {NBYTES{imm}};
            FORM_MASK: pat = mask_v;
            default:   pat = '0;
        endcase
    end
endmodule

// File: rtl/movi_regfile.sv
module movi_regfile #(
    parameter int NUM_REGS = 32,
    parameter int VEC_W    = 128,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [VEC_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [VEC_W-1:0] rdata
);
    logic [VEC_W-1:0] regs [NUM_REGS];

    for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                regs[e] <= '0;
            else if (we && widx == IDX_W'(e))
                regs[e] <= wdata;
        end
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/movi_unit.sv
module movi_unit
    import movi_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int VEC_W   = 2 * PAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [IMM_W-1:0]  cmd_imm8,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic              cmd_op,
    input  logic              cmd_q,
    input  logic [IDX_W-1:0]  cmd_dst,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [VEC_W-1:0]  wr_data,
    output logic              illegal,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [VEC_W-1:0]  rd_data
);
    ctl_state_e       state, state_nx;
    form_e            form;
    logic [PAT_W-1:0] pat;
    logic             accept;
    logic             stg_vld, stg_bad;
    logic [IDX_W-1:0] stg_idx;
    logic [VEC_W-1:0] stg_data;

    movi_decode u_dec (.mode(cmd_mode), .op(cmd_op), .form(form));
    movi_expand u_exp (.form(form), .mode(cmd_mode), .imm(cmd_imm8), .pat(pat));

    // next state
    always_comb begin
        unique case (state)
            ST_INIT:   state_nx = ST_ACTIVE;   // INIT_TO_ACTIVE
            ST_ACTIVE: state_nx = ST_ACTIVE;
            default:   state_nx = ST_INIT;
        endcase
    end

    // state register (ACTIVE_TO_INIT through reset)
    always_ff @(posedge clk) begin
        if (rst) state <= ST_INIT;
        else     state <= state_nx;
    end

    // outputs of the control
    always_comb begin
        unique case (state)
            ST_ACTIVE: cmd_ready = 1'b1;
            default:   cmd_ready = 1'b0;
        endcase
        accept = cmd_valid && cmd_ready;
    end

    // single stage between acceptance and write
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld  <= 1'b0;
            stg_bad  <= 1'b0;
            stg_idx  <= '0;
            stg_data <= '0;
        end else begin
            stg_vld <= accept;
            if (accept) begin
                stg_bad  <= (form == FORM_BAD);
                stg_idx  <= cmd_dst;
                stg_data <= cmd_q ? {pat, pat} : {{PAT_W{1'b0}}, pat};
            end
        end
    end

    assign wr_en   = stg_vld && !stg_bad;
    assign illegal = stg_vld && stg_bad;
    assign wr_idx  = stg_idx;
    assign wr_data = stg_data;

    movi_regfile #(.NUM_REGS(NUM_REGS), .VEC_W(VEC_W)) u_rf (
        .clk(clk), .rst(rst), .we(wr_en), .widx(stg_idx), .wdata(stg_data),
        .ridx(rd_idx), .rdata(rd_data)
    );
endmodule

// File: rtl/movi_unit_chk.sv
module movi_unit_chk #(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [3:0]       cmd_mode,
    input logic             cmd_q,
    input logic [IDX_W-1:0] cmd_dst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [127:0]     wr_data,
    input logic             illegal,
    input logic [IDX_W-1:0] rd_idx,
    input logic [127:0]     rd_data
);
    logic acc, bad_mode;
    assign acc      = cmd_valid && cmd_ready;
    assign bad_mode = (!cmd_mode[3] && cmd_mode[0]) ||
                      (cmd_mode[3:2] == 2'b10 && cmd_mode[0]) ||
                      (cmd_mode == 4'b1111);

    assert_ready_low_in_reset_R1: assert property (@(posedge clk) rst |=> !cmd_ready);

    assert_ready_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cmd_ready);

    assert_legal_writes_next_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && !bad_mode) |=> (wr_en && wr_idx == $past(cmd_dst)));

    assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (acc && bad_mode) |=> (illegal && !wr_en));

    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (!wr_en && !illegal));

    assert_upper_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && !bad_mode && !cmd_q) |=> (wr_data[127:64] == 64'd0));

    assert_readback_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_idx != $past(wr_idx) || rd_data == $past(wr_data)));

    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, illegal}));
endmodule

bind movi_unit movi_unit_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_q(cmd_q), .cmd_dst(cmd_dst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal),
    .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/tb_movi_unit.sv
module tb_movi_unit;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [7:0]   cmd_imm8 = '0;
    logic [3:0]   cmd_mode = '0;
    logic         cmd_op = 1'b0;
    logic         cmd_q = 1'b0;
    logic [4:0]   cmd_dst = '0;
    logic         wr_en;
    logic [4:0]   wr_idx;
    logic [127:0] wr_data;
    logic         illegal;
    logic [4:0]   rd_idx = '0;
    logic [127:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [127:0] shadow [32];

    always #(CLK_P/2) clk = ~clk;

    movi_unit dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent model of the expansion
    function automatic logic [127:0] model(input logic [7:0] imm, input logic [3:0] m,
                                           input logic op, input logic q, output bit bad);
        logic [63:0] p;
        logic [31:0] w;
        logic [15:0] h;
        bad = 1'b0;
        p = '0;
        if (m[3] == 1'b0 && m[0] == 1'b0) begin
            w = 32'(imm) * (32'd1 << (8 * m[2:1]));
            p = {w, w};
        end else if (m[3:2] == 2'b10 && m[0] == 1'b0) begin
            h = m[1] ? {imm, 8'h00} : {8'h00, imm};
            p = {h, h, h, h};
        end else if (m[3:1] == 3'b110) begin
            w = m[0] ? {8'h00, imm, 16'hFFFF} : {16'h0000, imm, 8'hFF};
            p = {w, w};
        end else if (m == 4'b1110) begin
            for (int k = 0; k < 8; k++)
                p[8*k +: 8] = op ? (imm[k] ? 8'hFF : 8'h00) : imm;
        end else begin
            bad = 1'b1;
        end
        return q ? {p, p} : {64'd0, p};
    endfunction

    task automatic readback(input logic [4:0] idx, input string req);
        rd_idx = idx;
        #1;
        chk(rd_data === shadow[idx], req, rd_data, shadow[idx]);
    endtask

    // one command, isolated: checks ready, write port, pulse width, read-back
    task automatic do_cmd(input logic [7:0] imm, input logic [3:0] m, input logic op,
                          input logic q, input logic [4:0] dst, input string req);
        bit bad;
        logic [127:0] exp;
        exp = model(imm, m, op, q, bad);
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R2 ready", 128'(cmd_ready), 128'd1);
        cmd_valid = 1'b1; cmd_imm8 = imm; cmd_mode = m; cmd_op = op; cmd_q = q; cmd_dst = dst;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (bad) begin
            chk(illegal === 1'b1 && wr_en === 1'b0, {req, " R9 flag"}, {126'd0, illegal, wr_en}, 128'd2);
        end else begin
            chk(wr_en === 1'b1 && wr_idx === dst, {req, " R10 strobe"}, {wr_en, 122'd0, wr_idx}, {1'b1, 122'd0, dst});
            chk(wr_data === exp, req, wr_data, exp);
            shadow[dst] = exp;
        end
        @(negedge clk);
        chk(wr_en === 1'b0 && illegal === 1'b0, "R10 single pulse", {126'd0, wr_en, illegal}, 128'd0);
        readback(dst, {req, " readback"});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_ready === 1'b0, "R1 ready low", 128'(cmd_ready), 128'd0);
        chk(wr_en === 1'b0 && illegal === 1'b0, "R1 outputs idle", {126'd0, wr_en, illegal}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R2 ready after release", 128'(cmd_ready), 128'd1);
        for (int i = 0; i < 32; i++) begin
            shadow[i] = '0;
            readback(5'(i), "R1 reg zero");
        end
    endtask

    task automatic t_word();
        for (int s = 0; s < 4; s++)
            do_cmd(8'hA5, {1'b0, 2'(s), 1'b0}, 1'b0, 1'b1, 5'(1 + s), "R3 word");
        do_cmd(8'h3C, 4'b0110, 1'b0, 1'b0, 5'd5, "R3 word q0");
    endtask

    task automatic t_half();
        do_cmd(8'h81, 4'b1000, 1'b0, 1'b1, 5'd6, "R4 half lo");
        do_cmd(8'h81, 4'b1010, 1'b0, 1'b1, 5'd7, "R4 half hi");
    endtask

    task automatic t_ones();
        do_cmd(8'h12, 4'b1100, 1'b0, 1'b1, 5'd8, "R5 ones 8");
        do_cmd(8'h12, 4'b1101, 1'b0, 1'b1, 5'd9, "R5 ones 16");
        do_cmd(8'h00, 4'b1101, 1'b0, 1'b0, 5'd10, "R5 ones zero imm");
    endtask

    task automatic t_byte_mask();
        do_cmd(8'h5E, 4'b1110, 1'b0, 1'b1, 5'd11, "R6 byte");
        do_cmd(8'b1000_0001, 4'b1110, 1'b1, 1'b1, 5'd12, "R7 mask ends");
        do_cmd(8'b0110_1010, 4'b1110, 1'b1, 1'b0, 5'd13, "R7 mask mixed");
    endtask

    task automatic t_q();
        do_cmd(8'hFF, 4'b1110, 1'b0, 1'b1, 5'd14, "R8 fill");
        do_cmd(8'h77, 4'b0000, 1'b0, 1'b0, 5'd14, "R8 upper cleared");
        do_cmd(8'h77, 4'b0000, 1'b0, 1'b1, 5'd15, "R8 doubled");
    endtask

    task automatic t_illegal();
        logic [3:0] bad_modes [7] = '{4'b0001, 4'b0011, 4'b0101, 4'b0111, 4'b1001, 4'b1011, 4'b1111};
        for (int i = 0; i < 7; i++) begin
            do_cmd(8'hC3, bad_modes[i], 1'b0, 1'b1, 5'd11, "R9 illegal");
            do_cmd(8'hC3, bad_modes[i], 1'b1, 1'b0, 5'd12, "R9 illegal op1");
        end
    endtask

    task automatic t_op_ignored();
        do_cmd(8'h9B, 4'b0100, 1'b1, 1'b1, 5'd16, "R11 op word");
        do_cmd(8'h9B, 4'b1010, 1'b1, 1'b1, 5'd17, "R11 op half");
        do_cmd(8'h9B, 4'b1101, 1'b1, 1'b1, 5'd18, "R11 op ones");
    endtask

    task automatic t_b2b();
        bit b;
        logic [127:0] ea, eb;
        ea = model(8'h11, 4'b0010, 1'b0, 1'b1, b);
        eb = model(8'h22, 4'b1110, 1'b1, 1'b1, b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_imm8 = 8'h11; cmd_mode = 4'b0010; cmd_op = 1'b0; cmd_q = 1'b1; cmd_dst = 5'd20;
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R2 b2b ready", 128'(cmd_ready), 128'd1);
        chk(wr_en === 1'b1 && wr_idx === 5'd20 && wr_data === ea, "R10 b2b first", wr_data, ea);
        cmd_imm8 = 8'h22; cmd_mode = 4'b1110; cmd_op = 1'b1; cmd_dst = 5'd31;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(wr_en === 1'b1 && wr_idx === 5'd31 && wr_data === eb, "R2 b2b second", wr_data, eb);
        shadow[20] = ea;
        shadow[31] = eb;
        @(negedge clk);
        readback(5'd20, "R10 b2b readback a");
        readback(5'd31, "R10 b2b readback b");
    endtask

    initial begin
        t_reset();
        t_word();
        t_half();
        t_ones();
        t_byte_mask();
        t_q();
        t_illegal();
        t_op_ignored();
        t_b2b();
        for (int i = 0; i < 32; i++) readback(5'(i), "R10 final regfile");
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule